// File: doc/BRIEF.md
# Hall-Sensed Three-Phase Commutator

This block converts three already-synchronized Hall sensor levels into on/off commands for the high-side and low-side switches of three half-bridges. Each leg of the bridge ends up in one of three states: sourcing (high side on), sinking (low side on) or floating (both off). A direction select reverses rotation by complementing the Hall code before the lookup. A PWM-on request chops the high side of the sourcing leg. While the request is low, the low side of that same leg conducts for synchronous rectification.

A fixed order of overrides sits above normal commutation. From highest to lowest it is: over-temperature, invalid Hall code, undervoltage brake, stop brake, then rotor-lock latch. Every leg has its own dead-time sequencer. Once one switch of a leg turns off, the other switch of that leg cannot turn on until a parameterized number of clock cycles has passed.

Top module: `hall_commutator`

## Requirements
- R1: Forward direction (`dir_rev_i`=0). Let `hall_i`={s1,s2,s3} with s1 in bit 2. Leg k drives bit k-1 of both output vectors. The source leg and sink leg for each code are: 101 gives src 2, snk 1; 100 gives src 3, snk 1; 110 gives src 3, snk 2; 010 gives src 1, snk 2; 011 gives src 1, snk 3; 001 gives src 2, snk 3. The remaining leg is off.
- R2: With `dir_rev_i`=1, the bitwise complement of a forward code produces the same outputs that the forward code gives in R1.
- R3: In normal mode the sink leg holds its low side on. The source leg's high side follows `pwm_on_i`. While `pwm_on_i`=0 the source leg's low side is on instead. The floating leg has both switches off.
- R4: A Hall code of 000 or 111 turns all six switches off, whatever the state of `uv_i`, `stop_i`, `lock_i` and `pwm_on_i`.
- R5: With `stop_i`=1 and a valid code, all high sides are off and all low sides are on (short brake).
- R6: With `uv_i`=1 and a valid code, the result is the same brake as R5 regardless of `pwm_on_i`, `stop_i` and `lock_i`. There is no synchronous-rectification switching in this mode.
- R7: `ot_i`=1 turns all six switches off and overrides every other input.
- R8: With `lock_i`=1 in otherwise normal mode, all high sides are off and only the sink leg's low side is on.
- R9: Within a leg, a switch turns on only after both switches of that leg have been off for at least `DEAD_CYC` cycles. When a leg swaps sides, the both-off gap is exactly `DEAD_CYC` cycles.
- R10: No leg ever has its high and low side on at the same time.
- R11: A switch turns off on the first clock edge after its request drops. A switch on an idle leg (gap already elapsed) turns on at the first edge after its request rises.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_i | input | 3 | Hall levels {s1,s2,s3} |
| dir_rev_i | input | 1 | 1 selects reverse rotation |
| pwm_on_i | input | 1 | PWM on-phase request |
| stop_i | input | 1 | Stop / short-brake request |
| uv_i | input | 1 | Undervoltage brake request |
| ot_i | input | 1 | Over-temperature, all switches off |
| lock_i | input | 1 | Rotor-lock latch active |
| hs_on_o | output | 3 | High-side switch on, bit k-1 = leg k |
| ls_on_o | output | 3 | Low-side switch on, bit k-1 = leg k |

## Verification
Mode decoding is combinational and each leg has one register stage, so every turn-off and every idle-leg turn-on is due one edge after the input change. A turn-on that follows a turn-off in the same leg is due `DEAD_CYC`+1 edges after the change. Inputs are applied and outputs sampled 1 ns after a rising edge. Steady-state checks wait `DEAD_CYC`+3 edges so that any pending dead-time gap has elapsed. The dead-time test samples one edge after the change, then after `DEAD_CYC` edges (the switch must still be off), then after `DEAD_CYC`+1 edges (the switch must now be on).

// File: rtl/hcomm_pkg.sv
package hcomm_pkg;
    localparam int NLEG = 3;

    typedef struct packed {
        logic       ok;
        logic [2:0] src;
        logic [2:0] snk;
    } hall_sel_t;

    // one-hot source / sink legs for a forward-direction Hall code
    function automatic hall_sel_t hall_lookup(input logic [2:0] code);
        hall_sel_t r;
        r = '{ok: 1'b1, src: 3'b000, snk: 3'b000};
        case (code)
            3'b101: begin r.src = 3'b010; r.snk = 3'b001; end
            3'b100: begin r.src = 3'b100; r.snk = 3'b001; end
            3'b110: begin r.src = 3'b100; r.snk = 3'b010; end
            3'b010: begin r.src = 3'b001; r.snk = 3'b010; end
            3'b011: begin r.src = 3'b001; r.snk = 3'b100; end
            3'b001: begin r.src = 3'b010; r.snk = 3'b100; end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/hcomm_mode.sv
module hcomm_mode
    import hcomm_pkg::*;
(
    input  logic [2:0]      hall_i,
    input  logic            dir_rev_i,
    input  logic            pwm_on_i,
    input  logic            stop_i,
    input  logic            uv_i,
    input  logic            ot_i,
    input  logic            lock_i,
    output logic [NLEG-1:0] want_hi_o,
    output logic [NLEG-1:0] want_lo_o
);
    logic [2:0] code_eff;
    hall_sel_t  sel;

    always_comb begin
        code_eff  = dir_rev_i ? ~hall_i : hall_i;
        sel       = hall_lookup(code_eff);
        want_hi_o = '0;
        want_lo_o = '0;
        if (ot_i) begin
            // everything off
        end else if (!sel.ok) begin
            // invalid code: everything off
        end else if (uv_i || stop_i) begin
            want_lo_o = '1;
        end else begin
            want_lo_o = sel.snk;
            if (!lock_i) begin
                if (pwm_on_i) want_hi_o = sel.src;
                else          want_lo_o = sel.snk | sel.src;
            end
        end
    end
endmodule

// File: rtl/hcomm_leg.sv
module hcomm_leg #(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi_i,
    input  logic want_lo_i,
    output logic hs_o,
    output logic ls_o
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [CW-1:0] gap;
    } leg_t;

    leg_t st_d, st_q;
    logic drop;
    logic clear;

    always_comb begin
        st_d  = st_q;
        clear = (st_q.gap == '0);
        drop  = (st_q.hs && !want_hi_i) || (st_q.ls && !want_lo_i);
        st_d.hs = want_hi_i && (st_q.hs || (!st_q.ls && clear));
        st_d.ls = want_lo_i && (st_q.ls || (!st_q.hs && clear));
        if (drop)        st_d.gap = LOAD;
        else if (!clear) st_d.gap = st_q.gap - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hcomm_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_rev_i,
    input  logic       pwm_on_i,
    input  logic       stop_i,
    input  logic       uv_i,
    input  logic       ot_i,
    input  logic       lock_i,
    output logic [2:0] hs_on_o,
    output logic [2:0] ls_on_o
);
    logic [NLEG-1:0] want_hi;
    logic [NLEG-1:0] want_lo;

    hcomm_mode mode_i (
        .hall_i    (hall_i),
        .dir_rev_i (dir_rev_i),
        .pwm_on_i  (pwm_on_i),
        .stop_i    (stop_i),
        .uv_i      (uv_i),
        .ot_i      (ot_i),
        .lock_i    (lock_i),
        .want_hi_o (want_hi),
        .want_lo_o (want_lo)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hcomm_leg #(.DEAD_CYC(DEAD_CYC)) leg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_hi_i (want_hi[g]),
            .want_lo_i (want_lo[g]),
            .hs_o      (hs_on_o[g]),
            .ls_o      (ls_on_o[g])
        );
    end
endmodule

// File: rtl/hcomm_chk.sv
module hcomm_chk #(
    parameter int DEAD_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       stop_i,
    input logic       uv_i,
    input logic       ot_i,
    input logic       lock_i,
    input logic [2:0] hs_on_o,
    input logic [2:0] ls_on_o
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    logic [CW-1:0] idle_q [3];

    for (genvar g = 0; g < 3; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n)                          idle_q[g] <= SAT;
            else if (hs_on_o[g] || ls_on_o[g])   idle_q[g] <= '0;
            else if (idle_q[g] != SAT)           idle_q[g] <= idle_q[g] + 1'b1;
        end

        // R9
        dead_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_on_o[g]) |-> idle_q[g] == SAT);
        // R9
        dead_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls_on_o[g]) |-> idle_q[g] == SAT);
    end

    // R10
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on_o & ls_on_o) == 3'b000);
    // R7
    ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_i |=> (hs_on_o == 3'b000 && ls_on_o == 3'b000));
    // R4
    bad_hall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_i == 3'b000 || hall_i == 3'b111) |=> (hs_on_o == 3'b000 && ls_on_o == 3'b000));
    // R5 R6
    brake_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i || uv_i) |=> hs_on_o == 3'b000);
    // R8
    lock_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> hs_on_o == 3'b000);
endmodule

bind hall_commutator hcomm_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (.*);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
    localparam int DEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b101;
    logic       dir_rev_i = 1'b0, pwm_on_i = 1'b1, stop_i = 1'b0;
    logic       uv_i = 1'b0, ot_i = 1'b0, lock_i = 1'b0;
    logic [2:0] hs_on_o, ls_on_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    hall_commutator #(.DEAD_CYC(DEAD)) dut_i (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        edges(DEAD + 3);
    endtask

    task automatic chk(input string req, input logic [2:0] exp_hs, input logic [2:0] exp_ls);
        total++;
        if (hs_on_o !== exp_hs || ls_on_o !== exp_ls) begin
            bad++;
            $display("FAIL %s: act hs=%b ls=%b exp hs=%b ls=%b", req, hs_on_o, ls_on_o, exp_hs, exp_ls);
        end
    endtask

    // forward table from R1: source / sink one-hot masks
    function automatic logic [5:0] fwd(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        edges(3);
        chk("R12 reset", 3'b000, 3'b000);
        rst_n = 1'b1;
        edges(1); // idle leg turns on at first edge
        chk("R11 idle turn-on", 3'b010, 3'b001);
    endtask

    task automatic t_forward();
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        dir_rev_i = 1'b0; pwm_on_i = 1'b1;
        foreach (codes[i]) begin
            logic [5:0] m;
            m = fwd(codes[i]);
            hall_i = codes[i];
            settle();
            chk("R1 forward", m[5:3], m[2:0]);
        end
    endtask

    task automatic t_reverse();
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        dir_rev_i = 1'b1; pwm_on_i = 1'b1;
        foreach (codes[i]) begin
            logic [5:0] m;
            m = fwd(codes[i]);
            hall_i = ~codes[i];
            settle();
            chk("R2 reverse", m[5:3], m[2:0]);
        end
        dir_rev_i = 1'b0;
    endtask

    task automatic t_pwm_off();
        hall_i = 3'b110; pwm_on_i = 1'b0; // src leg3, snk leg2
        settle();
        chk("R3 sync rectification", 3'b000, 3'b110);
        hall_i = 3'b011; // src leg1, snk leg3
        settle();
        chk("R3 sync rectification", 3'b000, 3'b101);
        pwm_on_i = 1'b1;
        settle();
        chk("R3 pwm on", 3'b001, 3'b100);
    endtask

    task automatic t_dead();
        hall_i = 3'b101; pwm_on_i = 1'b1; // src leg2, snk leg1
        settle();
        pwm_on_i = 1'b0;
        edges(1);
        chk("R11 high off next edge", 3'b000, 3'b001);
        edges(DEAD - 1);
        chk("R9 low still off in gap", 3'b000, 3'b001);
        edges(1);
        chk("R9 low on after gap", 3'b000, 3'b011);
        pwm_on_i = 1'b1;
        edges(1);
        chk("R11 low off next edge", 3'b000, 3'b001);
        edges(DEAD - 1);
        chk("R9 high still off in gap", 3'b000, 3'b001);
        edges(1);
        chk("R9 high on after gap", 3'b010, 3'b001);
    endtask

    task automatic t_invalid();
        hall_i = 3'b000; uv_i = 1'b1; stop_i = 1'b1;
        edges(1);
        chk("R4 code 000 off", 3'b000, 3'b000);
        hall_i = 3'b111; uv_i = 1'b0; lock_i = 1'b1;
        settle();
        chk("R4 code 111 off", 3'b000, 3'b000);
        lock_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic t_brake();
        hall_i = 3'b010; pwm_on_i = 1'b1;
        settle();
        stop_i = 1'b1;
        settle();
        chk("R5 stop brake", 3'b000, 3'b111);
        stop_i = 1'b0; uv_i = 1'b1; lock_i = 1'b1;
        settle();
        chk("R6 uv brake", 3'b000, 3'b111);
        for (int k = 0; k < 6; k++) begin
            pwm_on_i = ~pwm_on_i;
            edges(2);
        end
        chk("R6 uv brake ignores pwm", 3'b000, 3'b111);
        uv_i = 1'b0; lock_i = 1'b0; pwm_on_i = 1'b1;
        settle();
    endtask

    task automatic t_ot();
        hall_i = 3'b100; stop_i = 1'b1; uv_i = 1'b1;
        settle();
        ot_i = 1'b1;
        edges(1);
        chk("R7 ot off next edge", 3'b000, 3'b000);
        stop_i = 1'b0; uv_i = 1'b0;
        settle();
        chk("R7 ot off normal", 3'b000, 3'b000);
        ot_i = 1'b0;
        settle();
        chk("R1 recover after ot", 3'b100, 3'b001);
    endtask

    task automatic t_lock();
        hall_i = 3'b001; pwm_on_i = 1'b1; lock_i = 1'b1; // src leg2, snk leg3
        settle();
        chk("R8 lock pwm on", 3'b000, 3'b100);
        pwm_on_i = 1'b0;
        settle();
        chk("R8 lock pwm off", 3'b000, 3'b100);
        lock_i = 1'b0;
        settle();
        chk("R3 after lock", 3'b000, 3'b110);
    endtask

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_pwm_off();
        t_dead();
        t_invalid();
        t_brake();
        t_ot();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule